// File: doc/BRIEF.md
# PHY Media Sense Sequencer

After reset this block works out the operating mode of an Ethernet MAC by talking to the attached PHY through a management master. It does not build MDIO frames itself. Instead it places one register access at a time on a request/response port, and an external MDIO engine carries each access out. The result is a set of mode bits: store-and-forward, full duplex, and alternate-PHY select. A done flag is raised once the sequence is complete. The mode bits hold their reset values until the sequence ends. All of them are then loaded in the same cycle that done rises.

A static strap selects a short variant. In that variant the block writes zero to the PHY control register, which forces 10 Mb/s operation, and then finishes. Otherwise the block polls the PHY status register until both the link bit and the autonegotiation-complete bit are set. If they are set, it reads a vendor status register to choose the duplex. If a timeout runs out first, it selects the alternate home-networking PHY. It then identifies that PHY and programs two of its registers. The values written depend on the PHY's identity and revision.

States: `S_BOOT` samples the strap. `S_FORCE_WR` writes the control register. `S_POLL_RD` polls status. `S_DUPLEX_RD` reads the vendor status. `S_ID_RD` reads the identifier. `S_VARIANT_RD` reads the variant register. `S_CFG_WR` writes the config register. `S_SRC_RD` reads the tuning source. `S_TUNE_WR` writes the tuning register. `S_COMMIT` loads the outputs. `S_DONE` idles.

Transitions: `S_BOOT` goes to `S_FORCE_WR` when the strap is high, and to `S_POLL_RD` otherwise. `S_POLL_RD` loops on itself until the link bits are set, which leads to `S_DUPLEX_RD`. It leaves to `S_ID_RD` if the timeout has expired. `S_ID_RD` goes to `S_VARIANT_RD` on an identity match and to `S_COMMIT` otherwise. The path then runs `S_VARIANT_RD` to `S_CFG_WR` to `S_SRC_RD` to `S_TUNE_WR` to `S_COMMIT`. `S_FORCE_WR` and `S_DUPLEX_RD` go to `S_COMMIT`, and `S_COMMIT` goes to `S_DONE`. Each access state first holds its request until it is accepted. It then waits for the response before it moves on.

Top module: `media_sense_seq`

## Requirements
- R1: While reset is held and after it is released, mode_sf is 1, mode_fd is 0, mode_alt is 0 and done is 0.
- R2: Every request carries PHY address `PHY_ADDR` (default 1). While req_valid is high and req_ready is low, the request fields stay unchanged.
- R3: With force_10m high, the only access is one write of 0x0000 to register 0. The block then finishes with mode_fd = 0 and mode_alt = 0.
- R4: Without the strap, register 1 is read repeatedly until both bit 2 and bit 5 of the read value are 1 (mask 0x0024). A value with only one of the two bits set counts as not ready.
- R5: Once the link bits are seen, register 17 is read. mode_fd becomes 1 if bit 15 or bit 13 of it is set (mask 0xA000). No writes are made on this path.
- R6: The timeout is `TIMEOUT_CYCLES` clock cycles counted from reset release. If a register 1 read returns not-ready after it has expired, mode_alt becomes 1 and mode_fd stays 0.
- R7: On the alternate path, register 3 is read. If (value AND 0xFFF0) is not 0xB900, the sequence ends with no writes.
- R8: If register 31 reads 0x4404, register 16 is written with 0x0005 when register 3 was exactly 0xB901, and with 0x1005 otherwise. Register 24 is then read, and register 25 is written with ((r24 + 3) AND 0x00FF) OR 0xF000.
- R9: If register 31 reads any other value, register 16 is written with 0x0005. Register 25 is then read, and written back with (r25 AND 0xFF00) + 2, using 16-bit arithmetic.
- R10: The mode bits keep their reset values until done rises, and they change in the same cycle as done. After that, done and the mode bits hold and no request is issued until the next reset.
- R11: Only one access is outstanding at a time. No request is raised between an accepted request and its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the sequence starts when it is released |
| force_10m | input | 1 | Static strap selecting the forced 10 Mb/s variant |
| req_valid | output | 1 | Management access request |
| req_ready | input | 1 | The MDIO master accepts the request in this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address |
| req_reg | output | 5 | PHY register number |
| req_wdata | output | 16 | Write data |
| resp_valid | input | 1 | One-cycle completion of the outstanding access |
| resp_rdata | input | 16 | Read data, valid with resp_valid |
| mode_sf | output | 1 | Store-and-forward mode bit |
| mode_fd | output | 1 | Full-duplex mode bit |
| mode_alt | output | 1 | Alternate-PHY select bit |
| done | output | 1 | Sequence complete; sticky until reset |

## Verification
A response sampled at a rising edge moves the sequencer on at that edge. The next request appears combinationally in the same cycle. After the final response, done and the mode bits rise together one clock edge later.

The bench drives the request/response port from a PHY model that acts on falling edges. Ready and response latencies are random, and the model logs each access in the cycle it is accepted. The bench checks that the mode bits keep their reset values on every falling edge before done. It compares them to the predicted values on the first falling edge where done is seen. It then watches ten more falling edges for any stray request or change.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        S_BOOT,
        S_FORCE_WR,
        S_POLL_RD,
        S_DUPLEX_RD,
        S_ID_RD,
        S_VARIANT_RD,
        S_CFG_WR,
        S_SRC_RD,
        S_TUNE_WR,
        S_COMMIT,
        S_DONE
    } seq_state_e;

    // PHY register numbers used by the sequence
    localparam logic [REG_W-1:0] RA_CTRL    = 5'd0;
    localparam logic [REG_W-1:0] RA_STATUS  = 5'd1;
    localparam logic [REG_W-1:0] RA_IDENT   = 5'd3;
    localparam logic [REG_W-1:0] RA_CONFIG  = 5'd16;
    localparam logic [REG_W-1:0] RA_VSTAT   = 5'd17;
    localparam logic [REG_W-1:0] RA_SRC_A   = 5'd24;
    localparam logic [REG_W-1:0] RA_TUNE    = 5'd25;
    localparam logic [REG_W-1:0] RA_VARIANT = 5'd31;

    // masks and match values
    localparam logic [DATA_W-1:0] LINK_MASK   = 16'h0024;
    localparam logic [DATA_W-1:0] DUPLEX_MASK = 16'hA000;
    localparam logic [DATA_W-1:0] ID_MASK     = 16'hFFF0;
    localparam logic [DATA_W-1:0] ID_FAMILY   = 16'hB900;
    localparam logic [DATA_W-1:0] ID_REV_NEW  = 16'hB901;
    localparam logic [DATA_W-1:0] VARIANT_A   = 16'h4404;
    localparam logic [DATA_W-1:0] CFG_SHORT   = 16'h0005;
    localparam logic [DATA_W-1:0] CFG_LONG    = 16'h1005;

endpackage

// File: rtl/msq_timeout.sv
module msq_timeout #(
    parameter int TIMEOUT_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (count != LIMIT) begin
            count <= count + 1'b1;
        end
    end

    assign expired = (count == LIMIT);
endmodule

// File: rtl/msq_calc.sv
module msq_calc
    import msq_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] id_word,
    input  logic              var_a,
    input  logic [DATA_W-1:0] src_word,
    output logic              link_up,
    output logic              fd_hit,
    output logic              id_match,
    output logic              var_hit,
    output logic [DATA_W-1:0] cfg_word,
    output logic [DATA_W-1:0] tune_word
);
    logic [DATA_W-1:0] sum_a;
    logic [DATA_W-1:0] tune_a;
    logic [DATA_W-1:0] tune_b;

    always_comb begin
        link_up  = ((rdata & LINK_MASK) == LINK_MASK);
        fd_hit   = ((rdata & DUPLEX_MASK) != '0);
        id_match = ((rdata & ID_MASK) == ID_FAMILY);
        var_hit  = (rdata == VARIANT_A);

        if (var_a && (id_word != ID_REV_NEW)) begin
            cfg_word = CFG_LONG;
        end else begin
            cfg_word = CFG_SHORT;
        end

        sum_a  = src_word + 16'd3;
        tune_a = {8'hF0, sum_a[7:0]};
        tune_b = {src_word[15:8], 8'h00} + 16'd2;
        tune_word = var_a ? tune_a : tune_b;
    end
endmodule

// File: rtl/msq_fsm.sv
module msq_fsm
    import msq_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_10m,
    input  logic              expired,
    input  logic              req_ready,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_rdata,
    input  logic              link_up,
    input  logic              fd_hit,
    input  logic              id_match,
    input  logic              var_hit,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] tune_word,
    output logic              req_valid,
    output logic              req_write,
    output logic [4:0]        req_phy,
    output logic [REG_W-1:0]  req_reg,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] id_word,
    output logic              var_a,
    output logic [DATA_W-1:0] src_word,
    output logic              mode_sf,
    output logic              mode_fd,
    output logic              mode_alt,
    output logic              done
);
    seq_state_e state, nxt;
    logic       waiting;
    logic       issuing;
    logic       fin;
    logic       fd_pend;
    logic       alt_pend;

    assign fin = waiting && resp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_BOOT;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_BOOT:       nxt = force_10m ? S_FORCE_WR : S_POLL_RD;
            S_FORCE_WR:   if (fin) nxt = S_COMMIT;
            S_POLL_RD: begin
                if (fin) begin
                    if (link_up)      nxt = S_DUPLEX_RD;
                    else if (expired) nxt = S_ID_RD;
                    else              nxt = S_POLL_RD;
                end
            end
            S_DUPLEX_RD:  if (fin) nxt = S_COMMIT;
            S_ID_RD:      if (fin) nxt = id_match ? S_VARIANT_RD : S_COMMIT;
            S_VARIANT_RD: if (fin) nxt = S_CFG_WR;
            S_CFG_WR:     if (fin) nxt = S_SRC_RD;
            S_SRC_RD:     if (fin) nxt = S_TUNE_WR;
            S_TUNE_WR:    if (fin) nxt = S_COMMIT;
            S_COMMIT:     nxt = S_DONE;
            S_DONE:       nxt = S_DONE;
            default:      nxt = S_BOOT;
        endcase
    end

    // request decode
    always_comb begin
        issuing   = 1'b1;
        req_write = 1'b0;
        req_reg   = RA_STATUS;
        req_wdata = '0;
        unique case (state)
            S_FORCE_WR: begin
                req_write = 1'b1;
                req_reg   = RA_CTRL;
            end
            S_POLL_RD:    req_reg = RA_STATUS;
            S_DUPLEX_RD:  req_reg = RA_VSTAT;
            S_ID_RD:      req_reg = RA_IDENT;
            S_VARIANT_RD: req_reg = RA_VARIANT;
            S_CFG_WR: begin
                req_write = 1'b1;
                req_reg   = RA_CONFIG;
                req_wdata = cfg_word;
            end
            S_SRC_RD:     req_reg = var_a ? RA_SRC_A : RA_TUNE;
            S_TUNE_WR: begin
                req_write = 1'b1;
                req_reg   = RA_TUNE;
                req_wdata = tune_word;
            end
            default:      issuing = 1'b0;
        endcase
        req_valid = issuing && !waiting;
        req_phy   = PHY_ADDR;
    end

    // access tracking and captured read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            fd_pend  <= 1'b0;
            alt_pend <= 1'b0;
            id_word  <= '0;
            var_a    <= 1'b0;
            src_word <= '0;
        end else begin
            if (req_valid && req_ready) begin
                waiting <= 1'b1;
            end else if (fin) begin
                waiting <= 1'b0;
            end
            if (fin) begin
                unique case (state)
                    S_POLL_RD:    if (!link_up && expired) alt_pend <= 1'b1;
                    S_DUPLEX_RD:  fd_pend  <= fd_hit;
                    S_ID_RD:      id_word  <= resp_rdata;
                    S_VARIANT_RD: var_a    <= var_hit;
                    S_SRC_RD:     src_word <= resp_rdata;
                    default:      ;
                endcase
            end
        end
    end

    // outputs, loaded once at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_sf  <= 1'b1;
            mode_fd  <= 1'b0;
            mode_alt <= 1'b0;
            done     <= 1'b0;
        end else if (state == S_COMMIT) begin
            mode_sf  <= 1'b1;
            mode_fd  <= fd_pend;
            mode_alt <= alt_pend;
            done     <= 1'b1;
        end
    end
endmodule

// File: rtl/media_sense_seq.sv
module media_sense_seq
    import msq_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR       = 5'd1,
    parameter int         TIMEOUT_CYCLES = 50_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        force_10m,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic [4:0]  req_phy,
    output logic [4:0]  req_reg,
    output logic [15:0] req_wdata,
    input  logic        resp_valid,
    input  logic [15:0] resp_rdata,
    output logic        mode_sf,
    output logic        mode_fd,
    output logic        mode_alt,
    output logic        done
);
    logic              expired;
    logic              link_up, fd_hit, id_match, var_hit, var_a;
    logic [DATA_W-1:0] cfg_word, tune_word, id_word, src_word;

    msq_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (expired)
    );

    msq_calc u_calc (
        .rdata     (resp_rdata),
        .id_word   (id_word),
        .var_a     (var_a),
        .src_word  (src_word),
        .link_up   (link_up),
        .fd_hit    (fd_hit),
        .id_match  (id_match),
        .var_hit   (var_hit),
        .cfg_word  (cfg_word),
        .tune_word (tune_word)
    );

    msq_fsm #(.PHY_ADDR(PHY_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_10m  (force_10m),
        .expired    (expired),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .link_up    (link_up),
        .fd_hit     (fd_hit),
        .id_match   (id_match),
        .var_hit    (var_hit),
        .cfg_word   (cfg_word),
        .tune_word  (tune_word),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_phy    (req_phy),
        .req_reg    (req_reg),
        .req_wdata  (req_wdata),
        .id_word    (id_word),
        .var_a      (var_a),
        .src_word   (src_word),
        .mode_sf    (mode_sf),
        .mode_fd    (mode_fd),
        .mode_alt   (mode_alt),
        .done       (done)
    );
endmodule

// File: rtl/msq_checker.sv
module msq_checker #(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        force_10m,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [4:0]  req_phy,
    input logic [4:0]  req_reg,
    input logic [15:0] req_wdata,
    input logic        resp_valid,
    input logic        mode_sf,
    input logic        mode_fd,
    input logic        mode_alt,
    input logic        done
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (req_valid && req_ready) begin
            outstanding <= 1'b1;
        end else if (resp_valid) begin
            outstanding <= 1'b0;
        end
    end

    assert_phy_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_phy == PHY_ADDR));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_reg)
                                       && $stable(req_write) && $stable(req_wdata)));

    assert_force_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (force_10m && req_valid) |-> (req_write && req_reg == 5'd0 && req_wdata == 16'h0000));

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_fd && mode_alt));

    assert_idle_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (mode_sf && !mode_fd && !mode_alt));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(mode_fd) && $stable(mode_alt) && mode_sf));

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    assert_single_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !req_valid);
endmodule

bind media_sense_seq msq_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_10m  (force_10m),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_phy    (req_phy),
    .req_reg    (req_reg),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .mode_sf    (mode_sf),
    .mode_fd    (mode_fd),
    .mode_alt   (mode_alt),
    .done       (done)
);

// File: tb/media_sense_seq_tb.sv
module media_sense_seq_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [4:0] TB_PHY     = 5'd7;
    localparam int         TB_TMO     = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_10m = 1'b0;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [4:0]  req_phy, req_reg;
    logic [15:0] req_wdata;
    logic        resp_valid = 1'b0;
    logic [15:0] resp_rdata = 16'h0;
    logic        mode_sf, mode_fd, mode_alt, done;

    int checks = 0;
    int fails  = 0;

    // PHY model state
    logic [15:0] regs [32];
    int          link_after;
    int          poll_reads, reads17, bad_addr, after_done, wr_cnt;
    logic [4:0]  wr_reg [8];
    logic [15:0] wr_dat [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    media_sense_seq #(.PHY_ADDR(TB_PHY), .TIMEOUT_CYCLES(TB_TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .force_10m(force_10m),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mode_sf(mode_sf), .mode_fd(mode_fd), .mode_alt(mode_alt), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // MDIO master model, acts on falling edges
    initial begin : phy_model
        bit          busy = 0;
        int          lat  = 0;
        logic [15:0] pend = 16'h0;
        forever begin
            @(negedge clk);
            resp_valid = 1'b0;
            req_ready  = 1'b0;
            if (!rst_n) begin
                busy = 0;
            end else if (busy) begin
                if (lat == 0) begin
                    resp_valid = 1'b1;
                    resp_rdata = pend;
                    busy = 0;
                end else begin
                    lat--;
                end
            end else if (req_valid && ($urandom % 3 != 0)) begin
                req_ready = 1'b1;
                busy = 1;
                lat  = $urandom % 3;
                if (done) after_done++;
                if (req_phy != TB_PHY) bad_addr++;
                if (req_write) begin
                    if (wr_cnt < 8) begin
                        wr_reg[wr_cnt] = req_reg;
                        wr_dat[wr_cnt] = req_wdata;
                    end
                    wr_cnt++;
                    regs[req_reg] = req_wdata;
                    pend = 16'h0;
                end else if (req_reg == 5'd1) begin
                    poll_reads++;
                    if (link_after != 0 && poll_reads >= link_after) pend = 16'h782D;
                    else if (poll_reads % 2 == 1) pend = 16'h7829;
                    else pend = 16'h780D;
                end else begin
                    if (req_reg == 5'd17) reads17++;
                    pend = regs[req_reg];
                end
            end
        end
    end

    task automatic run_case(input bit frc, input int la, input logic [15:0] r17,
                            input logic [15:0] r3, input logic [15:0] r31,
                            input logic [15:0] r24, input logic [15:0] r25);
        bit          e_fd, e_alt;
        int          e_cnt;
        logic [4:0]  e_reg [2];
        logic [15:0] e_dat [2];
        int          early_bad, waited;
        bit          sf0, fd0, alt0;

        // expected behaviour
        e_fd = 0; e_alt = 0; e_cnt = 0;
        e_reg[0] = 0; e_reg[1] = 0; e_dat[0] = 0; e_dat[1] = 0;
        if (frc) begin
            e_cnt = 1; e_reg[0] = 5'd0; e_dat[0] = 16'h0000;
        end else if (la != 0) begin
            e_fd = ((r17 & 16'hA000) != 0);
        end else begin
            e_alt = 1;
            if ((r3 & 16'hFFF0) == 16'hB900) begin
                e_cnt = 2;
                e_reg[0] = 5'd16; e_reg[1] = 5'd25;
                if (r31 == 16'h4404) begin
                    e_dat[0] = (r3 == 16'hB901) ? 16'h0005 : 16'h1005;
                    e_dat[1] = ((r24 + 16'd3) & 16'h00FF) | 16'hF000;
                end else begin
                    e_dat[0] = 16'h0005;
                    e_dat[1] = (r25 & 16'hFF00) + 16'd2;
                end
            end
        end

        // apply reset and program the model
        rst_n = 1'b0;
        force_10m = frc;
        for (int i = 0; i < 32; i++) regs[i] = 16'($urandom);
        regs[17] = r17; regs[3] = r3; regs[31] = r31; regs[24] = r24; regs[25] = r25;
        link_after = la;
        poll_reads = 0; reads17 = 0; bad_addr = 0; after_done = 0; wr_cnt = 0;
        repeat (3) @(negedge clk);
        chk(mode_sf && !mode_fd && !mode_alt && !done, "R1 in reset",
            {mode_sf, mode_fd, mode_alt, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_sf && !mode_fd && !mode_alt && !done, "R1 after release",
            {mode_sf, mode_fd, mode_alt, done}, 4'b1000);

        early_bad = 0; waited = 0;
        while (!done && waited < 3000) begin
            if (!(mode_sf && !mode_fd && !mode_alt)) early_bad++;
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R10 done reached", done, 1);
        chk(early_bad == 0, "R10 modes held before done", early_bad, 0);
        chk(mode_fd == e_fd, frc ? "R3 fd" : (la != 0 ? "R5 fd" : "R6 fd"), mode_fd, e_fd);
        chk(mode_alt == e_alt, e_alt ? "R6 alt" : "R5 alt", mode_alt, e_alt);
        chk(mode_sf == 1'b1, "R1 sf kept", mode_sf, 1);
        chk(wr_cnt == e_cnt, frc ? "R3 write count" : (e_alt ? "R7 write count" : "R5 write count"),
            wr_cnt, e_cnt);
        for (int i = 0; i < 2; i++) begin
            if (i < e_cnt && i < wr_cnt) begin
                chk(wr_reg[i] == e_reg[i], (r31 == 16'h4404) ? "R8 write reg" : "R9 write reg",
                    wr_reg[i], e_reg[i]);
                chk(wr_dat[i] == e_dat[i], frc ? "R3 write data" :
                    ((r31 == 16'h4404) ? "R8 write data" : "R9 write data"), wr_dat[i], e_dat[i]);
            end
        end
        chk(bad_addr == 0, "R2 phy address", bad_addr, 0);
        if (frc) chk(poll_reads == 0, "R3 no polling", poll_reads, 0);
        else if (la != 0) chk(poll_reads == la, "R4 poll count", poll_reads, la);
        else chk(poll_reads >= 1, "R6 polled before timeout", poll_reads, 1);
        chk(reads17 == ((!frc && la != 0) ? 1 : 0), "R5 reg17 reads", reads17,
            (!frc && la != 0) ? 1 : 0);

        sf0 = mode_sf; fd0 = mode_fd; alt0 = mode_alt;
        repeat (10) @(negedge clk);
        chk(done && mode_sf == sf0 && mode_fd == fd0 && mode_alt == alt0 && after_done == 0,
            "R10 quiet after done", after_done, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) regs[i] = 16'h0;
        link_after = 0; poll_reads = 0; reads17 = 0; bad_addr = 0; after_done = 0; wr_cnt = 0;

        // directed corners
        run_case(1, 0, 16'h0000, 16'hB901, 16'h4404, 16'h0000, 16'h0000); // R3 forced
        run_case(0, 1, 16'h8000, 16'h0, 16'h0, 16'h0, 16'h0);             // R5 bit 15
        run_case(0, 4, 16'h2000, 16'h0, 16'h0, 16'h0, 16'h0);             // R4 partial bits, R5 bit 13
        run_case(0, 2, 16'h5FFF, 16'h0, 16'h0, 16'h0, 16'h0);             // R5 half duplex
        run_case(0, 0, 16'hFFFF, 16'hB8FF, 16'h4404, 16'h0, 16'h0);       // R7 no match
        run_case(0, 0, 16'h0, 16'hB901, 16'h4404, 16'h00FE, 16'h0);       // R8 new rev
        run_case(0, 0, 16'h0, 16'hB90C, 16'h4404, 16'h12FF, 16'h0);       // R8 other rev, wrap
        run_case(0, 0, 16'h0, 16'hB900, 16'h4405, 16'h0, 16'hFFFF);       // R9 top byte
        run_case(0, 0, 16'h0, 16'hB901, 16'h0000, 16'h0, 16'h34A7);       // R9 new rev ignored

        // constrained random
        for (int n = 0; n < 24; n++) begin
            bit          frc;
            int          la;
            logic [15:0] r3, r31;
            frc = ($urandom % 8 == 0);
            la  = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 4);
            case ($urandom % 3)
                0:       r3 = 16'hB901;
                1:       r3 = 16'hB900 | 16'($urandom % 16);
                default: r3 = 16'($urandom);
            endcase
            r31 = ($urandom % 2 == 0) ? 16'h4404 : 16'($urandom);
            run_case(frc, la, 16'($urandom), r3, r31, 16'($urandom), 16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule